// File: doc/BRIEF.md
# Processor Status Flag Register with Write Merge

This block holds the 8-bit status register of a small processor core. In a single cycle it combines two sources of change. The first is the instruction's result being written back with the status register as its destination. The second is the flag update from the ALU for the same instruction, which covers zero, digit carry and carry. Per-bit merge rules decide which source each bit follows. Two hardware status bits (power-down and timeout style indicators) sit in the middle of the register. Software cannot change them. Only a dedicated hardware set/clear path can.

The decoder marks each flag the instruction affects with a strobe and supplies the new flag values. It can also raise a shield input together with a write. The shield stops the data write from reaching any of the three flag bits, so flags that are not affected keep their value. A clear-to-zero aimed at this register uses the shield, which gives the pattern 000u u1uu. A logical AND written back here leaves the shield low, so the carry and digit-carry bits take the written data while zero follows the ALU. All changes land on one rising clock edge and show on the output in the following cycle.

Top module: `stat_flag_merge`

## Requirements
- R1: A synchronous reset (rst_i high at a rising edge) loads 0x18: bits 4:3 set, every other bit cleared. This holds whatever the other inputs are doing.
- R2: With wr_en_i high, shield_i low and aff_i zero, bits 7:5 and 2:0 take wr_data_i on the next edge.
- R3: With wr_en_i low, each flag bit whose strobe aff_i[k] is high takes flag_i[k]; every other bit holds. The flag bits are carry at bit 0, digit carry at bit 1 and zero at bit 2, and aff_i and flag_i use the same bit positions.
- R4: When wr_en_i and aff_i[k] are both high, flag bit k takes flag_i[k] and not the written data. Flags with a low strobe take wr_data_i when shield_i is low.
- R5: Bits 4:3 never change because of wr_en_i or wr_data_i. With hw_set_i and hw_clr_i both zero they hold.
- R6: hw_set_i[j] sets bit 3+j and hw_clr_i[j] clears it. When both are high, set wins. This path acts regardless of any write.
- R7: With shield_i high during a write, flag bits whose strobe is low hold their value. A clear-to-zero (data 0x00, shield high, only zero affected with value 1) turns each prior value 0x18..0x1F into 0x1C..0x1F.
- R8: An AND with 0xF8 written back (data = prior & 0xF8, shield low, only zero affected, zero value 0) leaves 0x18 for every prior value 0x18..0x1F.
- R9: With no write, no strobe and no hardware set/clear, the register holds. Every update appears on status_o exactly one cycle after the inputs that cause it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_i | input | 1 | Synchronous reset, active high |
| wr_en_i | input | 1 | Instruction result is written to this register |
| wr_data_i | input | 8 | Result data for the write |
| shield_i | input | 1 | Block the data write from all three flag bits |
| aff_i | input | 3 | Per-flag "affected" strobes (bit0 C, bit1 DC, bit2 Z) |
| flag_i | input | 3 | New flag values from the ALU, same positions |
| hw_set_i | input | 2 | Hardware set for bits 4:3 (bit0 maps to bit 3) |
| hw_clr_i | input | 2 | Hardware clear for bits 4:3 |
| status_o | output | 8 | Current register value |

## Verification
The checker assumes every input is a known value at each rising edge. It also assumes that the reset is held for at least one edge before normal operation. The checks on flags and hardware bits allow any combination of inputs, including set and clear together and a write alongside every strobe. The bench therefore drives each input only on the falling edge, keeps every input known from time zero and asserts reset for two edges at the start. Its random phase then deliberately mixes writes, shields, strobes and hardware set/clear in one cycle.

// File: rtl/stat_pkg.sv
package stat_pkg;

    localparam int FLAG_W  = 3;
    localparam int HW_W    = 2;
    localparam int USER_W  = 3;
    localparam int REG_W   = FLAG_W + HW_W + USER_W;
    localparam int HW_LSB  = FLAG_W;
    localparam int USER_LSB = FLAG_W + HW_W;

    typedef struct packed {
        logic [USER_W-1:0] user;
        logic [HW_W-1:0]   hw;
        logic [FLAG_W-1:0] flags;
    } stat_t;

    localparam stat_t STAT_RST = '{user: '0, hw: '1, flags: '0};

endpackage

// File: rtl/stat_flag_sel.sv
module stat_flag_sel (
    input  logic cur_i,
    input  logic wr_en_i,
    input  logic wr_bit_i,
    input  logic shield_i,
    input  logic aff_i,
    input  logic flag_i,
    output logic nxt_o
);
    always_comb begin
        if (aff_i) begin
            nxt_o = flag_i;
        end else if (wr_en_i && !shield_i) begin
            nxt_o = wr_bit_i;
        end else begin
            nxt_o = cur_i;
        end
    end
endmodule

// File: rtl/stat_hw_bit.sv
module stat_hw_bit (
    input  logic cur_i,
    input  logic set_i,
    input  logic clr_i,
    output logic nxt_o
);
    always_comb begin
        if (set_i) begin
            nxt_o = 1'b1;
        end else if (clr_i) begin
            nxt_o = 1'b0;
        end else begin
            nxt_o = cur_i;
        end
    end
endmodule

// File: rtl/stat_plain_bits.sv
module stat_plain_bits #(
    parameter int W = 3
) (
    input  logic [W-1:0] cur_i,
    input  logic         wr_en_i,
    input  logic [W-1:0] data_i,
    output logic [W-1:0] nxt_o
);
    always_comb begin
        nxt_o = wr_en_i ? data_i : cur_i;
    end
endmodule

// File: rtl/stat_flag_merge.sv
module stat_flag_merge
    import stat_pkg::*;
(
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              wr_en_i,
    input  logic [REG_W-1:0]  wr_data_i,
    input  logic              shield_i,
    input  logic [FLAG_W-1:0] aff_i,
    input  logic [FLAG_W-1:0] flag_i,
    input  logic [HW_W-1:0]   hw_set_i,
    input  logic [HW_W-1:0]   hw_clr_i,
    output logic [REG_W-1:0]  status_o
);

    stat_t state_d, state_q;
    stat_t wr_view;

    logic [FLAG_W-1:0] flag_nxt;
    logic [HW_W-1:0]   hw_nxt;
    logic [USER_W-1:0] user_nxt;

    assign wr_view = stat_t'(wr_data_i);

    // Per-flag merge: ALU value for affected flags, data otherwise.
    for (genvar g = 0; g < FLAG_W; g++) begin : g_flag
        stat_flag_sel u_sel (
            .cur_i    (state_q.flags[g]),
            .wr_en_i  (wr_en_i),
            .wr_bit_i (wr_view.flags[g]),
            .shield_i (shield_i),
            .aff_i    (aff_i[g]),
            .flag_i   (flag_i[g]),
            .nxt_o    (flag_nxt[g])
        );
    end

    // Hardware status bits: no software path at all.
    for (genvar h = 0; h < HW_W; h++) begin : g_hw
        stat_hw_bit u_hw (
            .cur_i (state_q.hw[h]),
            .set_i (hw_set_i[h]),
            .clr_i (hw_clr_i[h]),
            .nxt_o (hw_nxt[h])
        );
    end

    stat_plain_bits #(.W(USER_W)) u_user (
        .cur_i   (state_q.user),
        .wr_en_i (wr_en_i),
        .data_i  (wr_view.user),
        .nxt_o   (user_nxt)
    );

    always_comb begin
        state_d       = state_q;
        state_d.flags = flag_nxt;
        state_d.hw    = hw_nxt;
        state_d.user  = user_nxt;
        if (rst_i) begin
            state_d = STAT_RST;
        end
    end

    always_ff @(posedge clk_i) begin
        state_q <= state_d;
    end

    assign status_o = state_q;

endmodule

// File: rtl/stat_flag_merge_chk.sv
module stat_flag_merge_chk
    import stat_pkg::*;
(
    input logic              clk_i,
    input logic              rst_i,
    input logic              wr_en_i,
    input logic [REG_W-1:0]  wr_data_i,
    input logic              shield_i,
    input logic [FLAG_W-1:0] aff_i,
    input logic [FLAG_W-1:0] flag_i,
    input logic [HW_W-1:0]   hw_set_i,
    input logic [HW_W-1:0]   hw_clr_i,
    input logic [REG_W-1:0]  status_o
);

    assert_reset_value_R1: assert property (@(posedge clk_i)
        rst_i |=> status_o == 8'h18);

    assert_user_write_R2: assert property (@(posedge clk_i) disable iff (rst_i)
        wr_en_i |=> status_o[7:5] == $past(wr_data_i[7:5]));

    assert_flag_follow_R3: assert property (@(posedge clk_i) disable iff (rst_i)
        (|aff_i) |=> ((status_o[2:0] ^ $past(flag_i)) & $past(aff_i)) == 3'b000);

    assert_unaffected_data_R4: assert property (@(posedge clk_i) disable iff (rst_i)
        (wr_en_i && !shield_i) |=>
            ((status_o[2:0] ^ $past(wr_data_i[2:0])) & ~$past(aff_i)) == 3'b000);

    assert_hw_readonly_R5: assert property (@(posedge clk_i) disable iff (rst_i)
        (hw_set_i == 2'b00 && hw_clr_i == 2'b00) |=> $stable(status_o[4:3]));

    assert_hw_set_wins_R6: assert property (@(posedge clk_i) disable iff (rst_i)
        (|hw_set_i) |=> (status_o[4:3] & $past(hw_set_i)) == $past(hw_set_i));

    assert_hw_clear_R6: assert property (@(posedge clk_i) disable iff (rst_i)
        (|(hw_clr_i & ~hw_set_i)) |=>
            (status_o[4:3] & $past(hw_clr_i & ~hw_set_i)) == 2'b00);

    assert_shield_hold_R7: assert property (@(posedge clk_i) disable iff (rst_i)
        (wr_en_i && shield_i) |=>
            ((status_o[2:0] ^ $past(status_o[2:0])) & ~$past(aff_i)) == 3'b000);

    assert_idle_hold_R9: assert property (@(posedge clk_i) disable iff (rst_i)
        (!wr_en_i && aff_i == 3'b000 && hw_set_i == 2'b00 && hw_clr_i == 2'b00)
            |=> $stable(status_o));

endmodule

bind stat_flag_merge stat_flag_merge_chk i_chk (.*);

// File: tb/test_stat_flag_merge.sv
module test_stat_flag_merge;

    localparam int PERIOD = 10;

    logic       clk_i = 1'b0;
    logic       rst_i = 1'b1;
    logic       wr_en_i = 1'b0;
    logic [7:0] wr_data_i = 8'h00;
    logic       shield_i = 1'b0;
    logic [2:0] aff_i = 3'b000;
    logic [2:0] flag_i = 3'b000;
    logic [1:0] hw_set_i = 2'b00;
    logic [1:0] hw_clr_i = 2'b00;
    logic [7:0] status_o;

    int n_checks = 0;
    int n_fail = 0;
    int model = 0;
    bit finished = 1'b0;

    always #(PERIOD/2) clk_i = ~clk_i;

    stat_flag_merge i_stat_flag_merge (.*);

    // Behavioural expectation of one clock edge.
    function automatic int predict(int cur);
        int r;
        r = cur;
        if (rst_i) return 8'h18;
        for (int b = 0; b < 8; b++) begin
            if (b == 3 || b == 4) begin
                if (hw_set_i[b-3]) r = r | (1 << b);
                else if (hw_clr_i[b-3]) r = r & ~(1 << b);
            end else if (b < 3) begin
                if (aff_i[b]) r = flag_i[b] ? (r | (1 << b)) : (r & ~(1 << b));
                else if (wr_en_i && !shield_i)
                    r = wr_data_i[b] ? (r | (1 << b)) : (r & ~(1 << b));
            end else if (wr_en_i) begin
                r = wr_data_i[b] ? (r | (1 << b)) : (r & ~(1 << b));
            end
        end
        return r;
    endfunction

    task automatic check(string req, int exp);
        n_checks++;
        if (status_o !== exp[7:0]) begin
            n_fail++;
            $display("FAIL %s: status_o=%02h expected=%02h", req, status_o, exp[7:0]);
        end
    endtask

    // Drive on falling edge, step one clock, compare on the next falling edge.
    task automatic step(string req, bit rst, bit we, int data, bit sh,
                        int aff, int flg, int hs, int hc);
        int exp;
        rst_i = rst; wr_en_i = we; wr_data_i = data[7:0]; shield_i = sh;
        aff_i = aff[2:0]; flag_i = flg[2:0]; hw_set_i = hs[1:0]; hw_clr_i = hc[1:0];
        exp = predict(model);
        @(posedge clk_i);
        @(negedge clk_i);
        model = exp;
        check(req, exp);
    endtask

    task automatic idle(string req);
        step(req, 0, 0, 0, 0, 0, 0, 0, 0);
    endtask

    initial begin
        @(negedge clk_i);
        step("R1", 1, 0, 0, 0, 0, 0, 0, 0);
        step("R1", 1, 1, 8'hFF, 0, 7, 7, 0, 3);
        check("R1", 8'h18);
        idle("R9");

        // R2: plain data write, no flags affected
        step("R2", 0, 1, 8'hA5, 0, 0, 0, 0, 0);
        check("R5", 8'hBD);
        step("R2", 0, 1, 8'h42, 0, 0, 0, 0, 0);
        check("R2", 8'h5A);
        idle("R9");

        // R3: flag-only update
        step("R3", 0, 0, 8'hFF, 0, 3'b101, 3'b001, 0, 0);
        check("R3", 8'h5B);
        step("R3", 0, 0, 8'h00, 1, 3'b010, 3'b010, 0, 0);

        // R4: write plus affected flags
        step("R4", 0, 1, 8'hE0, 0, 3'b100, 3'b100, 0, 0);
        check("R4", 8'hFC);
        step("R4", 0, 1, 8'h07, 0, 3'b011, 3'b000, 0, 0);

        // R6: hardware path
        step("R6", 0, 1, 8'hFF, 0, 0, 0, 0, 3);
        check("R6", 8'hE7);
        step("R6", 0, 0, 0, 0, 0, 0, 2'b01, 2'b11);
        check("R6", 8'hEF);
        step("R5", 0, 1, 8'h18, 0, 0, 0, 0, 0);
        check("R5", 8'h08);
        step("R6", 0, 0, 0, 0, 0, 0, 2'b11, 0);

        // R7 / R8: every prior value 0x18..0x1F
        for (int p = 8'h18; p <= 8'h1F; p++) begin
            step("R2", 0, 1, p, 0, 0, 0, 0, 0);
            step("R7", 0, 1, 8'h00, 1, 3'b100, 3'b100, 0, 0);
            check("R7", 8'h1C | (p & 3));
            step("R2", 0, 1, p, 0, 0, 0, 0, 0);
            step("R8", 0, 1, p & 8'hF8, 0, 3'b100, 3'b000, 0, 0);
            check("R8", 8'h18);
        end

        // Shield with a set of unaffected flags
        step("R2", 0, 1, 8'h1B, 0, 0, 0, 0, 0);
        step("R7", 0, 1, 8'hE4, 1, 3'b001, 3'b000, 0, 0);
        check("R7", 8'hFA);

        // Mixed random traffic against the model
        for (int i = 0; i < 400; i++) begin
            int u;
            u = $urandom;
            step("R9", (u[31:27] == 0), u[0], $urandom % 256, u[1],
                 u[4:2], u[7:5], (u[12:10] == 0) ? u[9:8] : 0,
                 (u[15:13] == 0) ? u[17:16] : 0);
            idle("R9");
        end

        finished = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        #(PERIOD * 100000);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

endmodule